// File: doc/BRIEF.md
# Listener Handshake with End-of-String Detection

This block is the receiving side of a byte-wide, three-wire interlocked parallel bus handshake. It samples the talker's data-valid line, takes a byte from the data lines, and drives the not-ready-for-data and not-data-accepted lines so that no byte is lost or taken twice. Each received byte sits in a one-byte receive register until the host reads it. While the byte waits, the block raises either an interrupt or a DMA request, depending on which one is enabled.

Every accepted byte is compared with a programmable end-of-string character. The comparison covers either the low seven bits or all eight bits. A byte that arrives with the end line asserted is flagged separately. Two holdoff options are available. The first keeps the bus not-ready after every byte. The second does so only after an end byte. In both cases the bus stays not-ready until the host writes a release command, even after the byte has been read. Bus lines are active-high inside the block, so a 1 means the line is asserted. Transceivers and the inversion to the physical bus lie outside it. The data-valid line goes through a synchronizer. The data and end lines are sampled directly, because the protocol holds them stable while data-valid is asserted.

Top module: `gpib_acceptor`

## Requirements
- R1: After reset, `nrfd_o`, `ndac_o`, `int_o`, `drq_o` and `rd_data_o` are all 0.
- R2: While `listen_en` is 1, the receive register is empty, no holdoff is pending and `dav_i` is 0, the block asserts `ndac_o` and releases `nrfd_o` one clock after `listen_en` rises.
- R3: When `dav_i` rises in the ready state, the byte on `dio_i` is stored, `nrfd_o` goes to 1 and `ndac_o` goes to 0, SYNC_STAGES+1 clocks later.
- R4: In the same cycle as R3, `int_o` rises if control bit 0 is 1 and `drq_o` rises if control bit 1 is 1. Both stay high until the byte is read.
- R5: When `dav_i` falls, `ndac_o` returns to 1 SYNC_STAGES+1 clocks later. `nrfd_o` stays at 1 while the byte is unread.
- R6: A read strobe with `cs_i`=1 and address 0 returns the stored byte one clock later. In the same clock it empties the register, drops `int_o`/`drq_o`, and releases `nrfd_o`, provided no holdoff is pending and `dav_i` has fallen.
- R7: A read strobe with `dack_i`=1 reads the data register regardless of `cs_i` and `addr_i`.
- R8: A status read (address 1) does not consume the byte and returns bit0 = byte present, bit1 = end-of-string match, bit2 = end line was asserted with the byte, bit3 = holdoff pending. With control bit 2 set to 1, the match compares all eight bits against the character written at address 0.
- R9: With control bit 2 set to 0, the match compares only bits 6:0, so bit 7 of the byte is ignored.
- R10: A byte received with `eoi_i`=1 sets status bit2.
- R11: With control bit 3 set to 1, `nrfd_o` stays at 1 after every byte, even once it has been read, until a write to address 2 (release). That write drops `nrfd_o` one clock later.
- R12: With control bit 4 set to 1, the holdoff of R11 applies only to bytes with an end-line or end-of-string match.
- R13: While `listen_en` is 0, `nrfd_o` and `ndac_o` are 0 one clock later and `dav_i` is not acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| listen_en | input | 1 | Listener addressed; enables the handshake |
| dav_i | input | 1 | Data valid from the talker (asynchronous) |
| eoi_i | input | 1 | End line, sampled with the byte |
| dio_i | input | DW | Bus data lines |
| nrfd_o | output | 1 | Not ready for data |
| ndac_o | output | 1 | Not data accepted |
| int_o | output | 1 | Byte waiting, interrupt form |
| drq_o | output | 1 | Byte waiting, DMA request form |
| cs_i | input | 1 | Register select |
| rd_stb_i | input | 1 | One-cycle read strobe |
| wr_stb_i | input | 1 | One-cycle write strobe |
| dack_i | input | 1 | DMA acknowledge; selects the data register |
| addr_i | input | AW | Register address |
| wr_data_i | input | DW | Write data: 0 = end character, 1 = control, 2 = release |
| rd_data_o | output | DW | Registered read data |

## Verification
A change on `dav_i` shows up on the bus outputs, the flags and the status SYNC_STAGES+1 rising edges later, which is three at the default setting. Register reads, register writes and `listen_en` take effect one rising edge after the strobe. The bench applies every stimulus on a falling edge and waits exactly those counts of falling edges before it samples, so each check sees its result half a clock after the edge that produced it. Holdoff and release are checked on `nrfd_o` after the data read and again after the release write. This shows that the read alone does not free the bus.

// File: rtl/ah_pkg.sv
package ah_pkg;
  typedef enum logic {AH_READY, AH_WAIT_NDAV} ah_state_e;

  typedef struct packed {
    logic hold_end;
    logic hold_all;
    logic eos_8bit;
    logic dma_en;
    logic int_en;
  } ah_ctrl_t;

  localparam int RA_DATA = 0;
  localparam int RA_STAT = 1;
  localparam int WA_EOS  = 0;
  localparam int WA_CTRL = 1;
  localparam int WA_REL  = 2;
endpackage

// File: rtl/ah_sync.sv
module ah_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/ah_eos_cmp.sv
module ah_eos_cmp #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] byte_i,
  input  logic [DW-1:0] eos_i,
  input  logic          full_width_i,
  output logic          match_o
);
  localparam int NARROW = DW - 1;

  always_comb begin
    if (full_width_i) match_o = (byte_i == eos_i);
    else              match_o = (byte_i[NARROW-1:0] == eos_i[NARROW-1:0]);
  end
endmodule

// File: rtl/gpib_acceptor.sv
module gpib_acceptor
  import ah_pkg::*;
#(
  parameter int DW          = 8,
  parameter int AW          = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          listen_en,
  input  logic          dav_i,
  input  logic          eoi_i,
  input  logic [DW-1:0] dio_i,
  output logic          nrfd_o,
  output logic          ndac_o,
  output logic          int_o,
  output logic          drq_o,
  input  logic          cs_i,
  input  logic          rd_stb_i,
  input  logic          wr_stb_i,
  input  logic          dack_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int CTRL_W = $bits(ah_ctrl_t);

  ah_state_e    state_q, state_n;
  ah_ctrl_t     ctrl_q;
  logic [DW-1:0] data_q, eos_char_q;
  logic          full_q, full_n, hold_q, hold_n;
  logic          eoi_flag_q, eos_flag_q;
  logic          dav_s, eos_match;
  logic          pop, stat_rd, wr_sel, rel_cmd, accept, end_byte;

  ah_sync #(.STAGES(SYNC_STAGES)) u_dav_sync (
    .clk(clk), .rst(rst), .d(dav_i), .q(dav_s)
  );

  ah_eos_cmp #(.DW(DW)) u_eos_cmp (
    .byte_i(dio_i), .eos_i(eos_char_q),
    .full_width_i(ctrl_q.eos_8bit), .match_o(eos_match)
  );

  assign pop      = rd_stb_i && (dack_i || (cs_i && addr_i == AW'(RA_DATA)));
  assign stat_rd  = rd_stb_i && !dack_i && cs_i && addr_i == AW'(RA_STAT);
  assign wr_sel   = wr_stb_i && cs_i && !dack_i;
  assign rel_cmd  = wr_sel && addr_i == AW'(WA_REL);
  assign accept   = listen_en && state_q == AH_READY && dav_s && !full_q && !hold_q;
  assign end_byte = eoi_i || eos_match;

  always_comb begin
    state_n = state_q;
    full_n  = full_q;
    hold_n  = hold_q;
    if (!listen_en)                               state_n = AH_READY;
    else if (accept)                              state_n = AH_WAIT_NDAV;
    else if (state_q == AH_WAIT_NDAV && !dav_s)   state_n = AH_READY;
    if (rel_cmd) hold_n = 1'b0;
    if (accept) begin
      full_n = 1'b1;
      hold_n = ctrl_q.hold_all || (ctrl_q.hold_end && end_byte);
    end else if (pop) begin
      full_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= AH_READY;
      full_q     <= 1'b0;
      hold_q     <= 1'b0;
      data_q     <= '0;
      eoi_flag_q <= 1'b0;
      eos_flag_q <= 1'b0;
      ctrl_q     <= '0;
      eos_char_q <= '0;
      nrfd_o     <= 1'b0;
      ndac_o     <= 1'b0;
      int_o      <= 1'b0;
      drq_o      <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      state_q <= state_n;
      full_q  <= full_n;
      hold_q  <= hold_n;
      if (accept) begin
        data_q     <= dio_i;
        eoi_flag_q <= eoi_i;
        eos_flag_q <= eos_match;
      end
      nrfd_o <= listen_en && (full_n || hold_n || state_n != AH_READY);
      ndac_o <= listen_en && state_n == AH_READY;
      int_o  <= full_n && ctrl_q.int_en;
      drq_o  <= full_n && ctrl_q.dma_en;
      if (wr_sel && addr_i == AW'(WA_EOS))  eos_char_q <= wr_data_i;
      if (wr_sel && addr_i == AW'(WA_CTRL)) ctrl_q <= ah_ctrl_t'(wr_data_i[CTRL_W-1:0]);
      if (pop)          rd_data_o <= data_q;
      else if (stat_rd) rd_data_o <= DW'({hold_q, eoi_flag_q, eos_flag_q, full_q});
    end
  end

  // R3: a newly stored byte always leaves the bus not-ready with acceptance released
  assert_accept_lines_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(full_q) |-> (nrfd_o && !ndac_o));

  // R4: the request outputs only signal a waiting byte
  assert_int_needs_byte_R4: assert property (@(posedge clk) disable iff (rst)
    int_o |-> full_q);
  assert_drq_needs_byte_R4: assert property (@(posedge clk) disable iff (rst)
    drq_o |-> full_q);

  // R6: the register empties only through a data read
  assert_empty_by_read_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(full_q) |-> $past(pop));

  // R11: a pending holdoff keeps the bus not-ready
  assert_hold_keeps_nrfd_R11: assert property (@(posedge clk) disable iff (rst)
    (hold_q && listen_en && !rel_cmd) |=> nrfd_o);

  // R13: not listening releases both handshake lines
  assert_idle_lines_R13: assert property (@(posedge clk) disable iff (rst)
    !listen_en |=> (!nrfd_o && !ndac_o));
endmodule

// File: tb/tb_gpib_acceptor.sv
module tb_gpib_acceptor;
  localparam int DW = 8;
  localparam int AW = 2;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst, listen_en, dav_i, eoi_i, cs_i, rd_stb_i, wr_stb_i, dack_i;
  logic [DW-1:0] dio_i, wr_data_i, rd_data_o;
  logic [AW-1:0] addr_i;
  logic nrfd_o, ndac_o, int_o, drq_o;
  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  gpib_acceptor #(.DW(DW), .AW(AW), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .listen_en(listen_en), .dav_i(dav_i), .eoi_i(eoi_i),
    .dio_i(dio_i), .nrfd_o(nrfd_o), .ndac_o(ndac_o), .int_o(int_o), .drq_o(drq_o),
    .cs_i(cs_i), .rd_stb_i(rd_stb_i), .wr_stb_i(wr_stb_i), .dack_i(dack_i),
    .addr_i(addr_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_stb_i = 1'b1; cs_i = 1'b1; addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_stb_i = 1'b0; cs_i = 1'b0;
  endtask

  task automatic rd_reg(input logic [AW-1:0] a, input logic use_dack, input logic sel, output logic [DW-1:0] d);
    @(negedge clk);
    rd_stb_i = 1'b1; cs_i = sel; addr_i = a; dack_i = use_dack;
    @(negedge clk);
    rd_stb_i = 1'b0; cs_i = 1'b0; dack_i = 1'b0;
    d = rd_data_o;
  endtask

  task automatic dav_up(input logic [DW-1:0] d, input logic e);
    @(negedge clk);
    dio_i = d; eoi_i = e; dav_i = 1'b1;
    repeat (LAT) @(negedge clk);
  endtask

  task automatic dav_down();
    dav_i = 1'b0;
    repeat (LAT) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1", "nrfd", nrfd_o, 0);
    check("R1", "ndac", ndac_o, 0);
    check("R1", "int", int_o, 0);
    check("R1", "drq", drq_o, 0);
    check("R1", "rd_data", rd_data_o, 0);
  endtask

  task automatic t_ready();
    @(negedge clk);
    listen_en = 1'b1;
    @(negedge clk);
    check("R2", "ndac ready", ndac_o, 1);
    check("R2", "nrfd ready", nrfd_o, 0);
  endtask

  task automatic t_basic();
    logic [DW-1:0] d;
    wr_reg(2'd0, 8'h0A);
    wr_reg(2'd1, 8'h01);
    dav_up(8'h55, 1'b0);
    check("R3", "nrfd after accept", nrfd_o, 1);
    check("R3", "ndac after accept", ndac_o, 0);
    check("R4", "int", int_o, 1);
    check("R4", "drq off", drq_o, 0);
    dav_down();
    check("R5", "ndac back", ndac_o, 1);
    check("R5", "nrfd held", nrfd_o, 1);
    rd_reg(2'd1, 1'b0, 1'b1, d);
    check("R8", "status plain byte", d, 8'h01);
    check("R8", "status read keeps nrfd", nrfd_o, 1);
    check("R8", "status read keeps int", int_o, 1);
    rd_reg(2'd0, 1'b0, 1'b1, d);
    check("R6", "data", d, 8'h55);
    check("R6", "nrfd released", nrfd_o, 0);
    check("R6", "int cleared", int_o, 0);
  endtask

  task automatic t_dma();
    logic [DW-1:0] d;
    wr_reg(2'd1, 8'h02);
    dav_up(8'hA3, 1'b0);
    check("R4", "drq", drq_o, 1);
    check("R4", "int off", int_o, 0);
    dav_down();
    rd_reg(2'd3, 1'b1, 1'b0, d);
    check("R7", "dack data", d, 8'hA3);
    check("R7", "drq cleared", drq_o, 0);
    check("R7", "nrfd released", nrfd_o, 0);
  endtask

  task automatic xfer_status(input logic [DW-1:0] b, input logic e, input logic [DW-1:0] exp_st, input string req);
    logic [DW-1:0] d;
    dav_up(b, e);
    dav_down();
    rd_reg(2'd1, 1'b0, 1'b1, d);
    check(req, "status", d, exp_st);
    rd_reg(2'd0, 1'b0, 1'b1, d);
    check(req, "data", d, b);
  endtask

  task automatic t_eos();
    wr_reg(2'd1, 8'h05);
    xfer_status(8'h0A, 1'b0, 8'h03, "R8");
    xfer_status(8'h8A, 1'b0, 8'h01, "R8");
    wr_reg(2'd1, 8'h01);
    xfer_status(8'h8A, 1'b0, 8'h03, "R9");
    xfer_status(8'h41, 1'b1, 8'h05, "R10");
  endtask

  task automatic t_hold_all();
    logic [DW-1:0] d;
    wr_reg(2'd1, 8'h09);
    dav_up(8'h12, 1'b0);
    dav_down();
    rd_reg(2'd1, 1'b0, 1'b1, d);
    check("R11", "status with hold", d, 8'h09);
    rd_reg(2'd0, 1'b0, 1'b1, d);
    check("R11", "data", d, 8'h12);
    check("R11", "nrfd held after read", nrfd_o, 1);
    wr_reg(2'd2, 8'h00);
    check("R11", "nrfd after release", nrfd_o, 0);
  endtask

  task automatic t_hold_end();
    logic [DW-1:0] d;
    wr_reg(2'd1, 8'h11);
    dav_up(8'h33, 1'b0);
    dav_down();
    rd_reg(2'd0, 1'b0, 1'b1, d);
    check("R12", "plain byte no hold", nrfd_o, 0);
    dav_up(8'h34, 1'b1);
    dav_down();
    rd_reg(2'd1, 1'b0, 1'b1, d);
    check("R12", "status end byte", d, 8'h0D);
    rd_reg(2'd0, 1'b0, 1'b1, d);
    check("R12", "end byte holds", nrfd_o, 1);
    wr_reg(2'd2, 8'h00);
    check("R12", "released", nrfd_o, 0);
  endtask

  task automatic t_listen_off();
    logic [DW-1:0] d;
    @(negedge clk);
    listen_en = 1'b0;
    @(negedge clk);
    check("R13", "nrfd off", nrfd_o, 0);
    check("R13", "ndac off", ndac_o, 0);
    dav_up(8'h77, 1'b0);
    dav_down();
    rd_reg(2'd1, 1'b0, 1'b1, d);
    check("R13", "no byte taken", d[0], 0);
    check("R13", "int quiet", int_o, 0);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; listen_en = 1'b0; dav_i = 1'b0; eoi_i = 1'b0; dio_i = '0;
    cs_i = 1'b0; rd_stb_i = 1'b0; wr_stb_i = 1'b0; dack_i = 1'b0;
    addr_i = '0; wr_data_i = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ready();
    t_basic();
    t_dma();
    t_eos();
    t_hold_all();
    t_hold_end();
    t_listen_off();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule